// File: doc/BRIEF.md
# Power-Capped Clock Boost Governor

This block picks the clock-frequency level index for a compute engine. Out of reset the level sits at a guaranteed floor, the base level. Each time a power sample arrives, the block compares the reading in watts with a programmable power target. A reading clearly under the target lifts the level by one programmable step. A reading clearly over the target brings it down by one step. A reading inside a small hysteresis band around the target leaves the level alone.

The level never goes below the base level. A raise never takes it past a programmable maximum, and the index never wraps. A clock generator outside this block follows the level index. It uses the one-cycle change strobe to start a frequency switch. Software programs the base, maximum, step and target through a simple write port. Any write takes effect from the next decision. A new base level above the current level lifts the level straight away, so the floor holds even between samples.

Top module: `boost_governor`

## Requirements
- R1: Synchronous active-high reset loads the level with the default base level (4), the default maximum level (24), the default step (1) and the default power target of 170 W; after reset `level_chg` is 0.
- R2: On a sample whose reading plus the hysteresis margin (5 W) is below the target, the level rises by exactly the step, once per sample.
- R3: A raise never lifts the level above the maximum level. It stops at the maximum, a level at or above the maximum holds, and the index never wraps.
- R4: On a sample whose reading is above the target plus the margin, the level falls by the step but never below the base level; a level at or below the base holds.
- R5: A reading within the band from target minus margin to target plus margin, both ends included, leaves the level unchanged and raises no strobe.
- R6: Without a sample strobe, and without a write to the base level, the level holds.
- R7: `level_chg` is high for exactly the cycle in which the new level first appears on `level`, and is low otherwise.
- R8: A write (`cfg_sel` 0 = base, 1 = maximum, 2 = step, 3 = target; level fields use the low bits of `cfg_wdata`) becomes visible at the clock edge that ends the write cycle. A sample in the same cycle as the write is decided with the old values.
- R9: A write of a base level above the current level (after that cycle's decision) moves the level up to the new base at the same edge and pulses `level_chg`.
- R10: With the default target of 170 W, a reading of 164 W raises the level, 165 W and 175 W hold, and 176 W lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | Power sample strobe, one decision per high cycle |
| sample_pwr | input | 10 | Power reading in watts |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 base, 1 maximum, 2 step, 3 target |
| cfg_wdata | input | 10 | Write data |
| level | output | 5 | Current clock level index |
| level_chg | output | 1 | One-cycle strobe when the level changes |

## Verification
Every result has a latency of one cycle. A sample or write placed on the inputs in one cycle shows up on `level` and `level_chg` right after the next rising edge. The driver applies stimulus on the falling edge and waits for the rising edge. Only then does it queue the expected level and strobe. The monitor pops that entry at the following falling edge, half a cycle after the outputs settle. Same-cycle collisions of a write with a sample are driven on purpose. In those cases the expected value uses the old configuration for the decision and the new base for the lift, as R8 and R9 require.

// File: rtl/boost_pkg.sv
package boost_pkg;

    localparam int LVL_W = 5;
    localparam int PWR_W = 10;

    typedef enum logic [1:0] {
        DEC_HOLD  = 2'd0,
        DEC_RAISE = 2'd1,
        DEC_LOWER = 2'd2
    } dec_e;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_MAX    = 2'd1,
        SEL_STEP   = 2'd2,
        SEL_TARGET = 2'd3
    } sel_e;

    typedef struct packed {
        logic [LVL_W-1:0] base;
        logic [LVL_W-1:0] top;
        logic [LVL_W-1:0] step;
        logic [PWR_W-1:0] target;
    } cfg_t;

endpackage

// File: rtl/boost_cfg_regs.sv
module boost_cfg_regs
    import boost_pkg::*;
#(
    parameter int BASE_DEF   = 4,
    parameter int MAX_DEF    = 24,
    parameter int STEP_DEF   = 1,
    parameter int TARGET_DEF = 170
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       sel,
    input  logic [PWR_W-1:0] wdata,
    output cfg_t             cfg
);

    logic [LVL_W-1:0] wlvl;
    assign wlvl = wdata[LVL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.base   <= LVL_W'(BASE_DEF);
            cfg.top    <= LVL_W'(MAX_DEF);
            cfg.step   <= LVL_W'(STEP_DEF);
            cfg.target <= PWR_W'(TARGET_DEF);
        end else if (wr_en) begin
            case (sel_e'(sel))
                SEL_BASE:   cfg.base   <= wlvl;
                SEL_MAX:    cfg.top    <= wlvl;
                SEL_STEP:   cfg.step   <= wlvl;
                SEL_TARGET: cfg.target <= wdata;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/boost_decide.sv
module boost_decide
    import boost_pkg::*;
#(
    parameter int HYST = 5
) (
    input  logic [PWR_W-1:0] pwr,
    input  logic [PWR_W-1:0] target,
    output dec_e             dec
);

    localparam int EXT_W = PWR_W + 1;

    logic [EXT_W-1:0] pwr_hi;
    logic [EXT_W-1:0] tgt_hi;

    assign pwr_hi = {1'b0, pwr} + EXT_W'(HYST);
    assign tgt_hi = {1'b0, target} + EXT_W'(HYST);

    always_comb begin
        if (pwr_hi < {1'b0, target})
            dec = DEC_RAISE;
        else if ({1'b0, pwr} > tgt_hi)
            dec = DEC_LOWER;
        else
            dec = DEC_HOLD;
    end

endmodule

// File: rtl/boost_level.sv
module boost_level
    import boost_pkg::*;
#(
    parameter int BASE_DEF = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp,
    input  dec_e             dec,
    input  cfg_t             cfg,
    input  logic             base_wr,
    input  logic [LVL_W-1:0] base_new,
    output logic [LVL_W-1:0] level_q,
    output logic             chg_q
);

    localparam int EXT_W = LVL_W + 1;

    logic [EXT_W-1:0] up_sum;
    logic [EXT_W-1:0] dn_diff;
    logic [LVL_W-1:0] decided;
    logic [LVL_W-1:0] nxt;

    assign up_sum  = {1'b0, level_q} + {1'b0, cfg.step};
    assign dn_diff = {1'b0, level_q} - {1'b0, cfg.step};

    always_comb begin
        decided = level_q;
        if (smp) begin
            if (dec == DEC_RAISE && level_q < cfg.top) begin
                if (up_sum > {1'b0, cfg.top})
                    decided = cfg.top;
                else
                    decided = up_sum[LVL_W-1:0];
            end else if (dec == DEC_LOWER && level_q > cfg.base) begin
                if (dn_diff[LVL_W] || dn_diff[LVL_W-1:0] < cfg.base)
                    decided = cfg.base;
                else
                    decided = dn_diff[LVL_W-1:0];
            end
        end
        nxt = decided;
        if (base_wr && base_new > decided)
            nxt = base_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= LVL_W'(BASE_DEF);
            chg_q   <= 1'b0;
        end else begin
            level_q <= nxt;
            chg_q   <= (nxt != level_q);
        end
    end

    // R4
    level_floor_chk: assert property (@(posedge clk) disable iff (rst)
        level_q >= cfg.base);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp && !base_wr) |=> $stable(level_q));

    // R7
    chg_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        chg_q == (level_q != $past(level_q)));

    // R2
    rise_step_chk: assert property (@(posedge clk) disable iff (rst)
        (smp && dec == DEC_RAISE && !base_wr) |=>
            (level_q >= $past(level_q)) &&
            ({1'b0, level_q} <= {1'b0, $past(level_q)} + {1'b0, $past(cfg.step)}));

    // R4
    fall_step_chk: assert property (@(posedge clk) disable iff (rst)
        (smp && dec == DEC_LOWER && !base_wr) |=> level_q <= $past(level_q));

    // R5
    band_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (smp && dec == DEC_HOLD && !base_wr) |=> !chg_q);

endmodule

// File: rtl/boost_governor.sv
module boost_governor
    import boost_pkg::*;
#(
    parameter int BASE_DEF   = 4,
    parameter int MAX_DEF    = 24,
    parameter int STEP_DEF   = 1,
    parameter int TARGET_DEF = 170,
    parameter int HYST       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_vld,
    input  logic [PWR_W-1:0] sample_pwr,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [PWR_W-1:0] cfg_wdata,
    output logic [LVL_W-1:0] level,
    output logic             level_chg
);

    cfg_t cfg;
    dec_e dec;
    logic base_wr;

    assign base_wr = cfg_wr && (sel_e'(cfg_sel) == SEL_BASE);

    boost_cfg_regs #(
        .BASE_DEF  (BASE_DEF),
        .MAX_DEF   (MAX_DEF),
        .STEP_DEF  (STEP_DEF),
        .TARGET_DEF(TARGET_DEF)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .wr_en(cfg_wr),
        .sel  (cfg_sel),
        .wdata(cfg_wdata),
        .cfg  (cfg)
    );

    boost_decide #(
        .HYST(HYST)
    ) u_decide (
        .pwr   (sample_pwr),
        .target(cfg.target),
        .dec   (dec)
    );

    boost_level #(
        .BASE_DEF(BASE_DEF)
    ) u_level (
        .clk     (clk),
        .rst     (rst),
        .smp     (sample_vld),
        .dec     (dec),
        .cfg     (cfg),
        .base_wr (base_wr),
        .base_new(cfg_wdata[LVL_W-1:0]),
        .level_q (level),
        .chg_q   (level_chg)
    );

    // R9
    base_lift_chk: assert property (@(posedge clk) disable iff (rst)
        base_wr |=> level >= $past(cfg_wdata[LVL_W-1:0]));

endmodule

// File: tb/tb_boost_governor.sv
`timescale 1ns/1ps
module tb_boost_governor;

    localparam int HYST = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_vld = 1'b0;
    logic [9:0] sample_pwr = '0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [9:0] cfg_wdata = '0;
    logic [4:0] level;
    logic       level_chg;

    always #10 clk = ~clk;

    boost_governor dut (
        .clk       (clk),
        .rst       (rst),
        .sample_vld(sample_vld),
        .sample_pwr(sample_pwr),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .level     (level),
        .level_chg (level_chg)
    );

    typedef struct {
        int    lvl;
        bit    chg;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    int m_lvl = 4, m_base = 4, m_max = 24, m_step = 1, m_tgt = 170;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic op(input string tag, input bit v, input int p,
                      input bit w, input int s, input int d);
        int   nl;
        exp_t e;
        @(negedge clk);
        sample_vld = v;
        sample_pwr = 10'(p);
        cfg_wr     = w;
        cfg_sel    = 2'(s);
        cfg_wdata  = 10'(d);
        nl = m_lvl;
        if (v) begin
            if (p + HYST < m_tgt) begin
                if (m_lvl < m_max)
                    nl = (m_lvl + m_step > m_max) ? m_max : m_lvl + m_step;
            end else if (p > m_tgt + HYST) begin
                if (m_lvl > m_base)
                    nl = (m_lvl - m_step < m_base) ? m_base : m_lvl - m_step;
            end
        end
        if (w) begin
            case (s)
                0: begin m_base = d; if (d > nl) nl = d; end
                1: m_max  = d;
                2: m_step = d;
                default: m_tgt = d;
            endcase
        end
        e.lvl = nl;
        e.chg = (nl != m_lvl);
        e.tag = tag;
        m_lvl = nl;
        @(posedge clk);
        #1 exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        op(tag, 0, 0, 0, 0, 0);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " level"}, int'(level), e.lvl);
            check({e.tag, " strobe"}, int'(level_chg), int'(e.chg));
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset level", int'(level), 4);
        check("R1 reset strobe", int'(level_chg), 0);

        idle("R6 idle");
        idle("R6 idle");
        op("R2 raise", 1, 100, 0, 0, 0);
        op("R2 raise", 1, 100, 0, 0, 0);
        op("R2 raise", 1, 100, 0, 0, 0);
        idle("R7 strobe drop");
        op("R5 band mid", 1, 170, 0, 0, 0);
        op("R10 band low edge", 1, 165, 0, 0, 0);
        op("R10 band high edge", 1, 175, 0, 0, 0);
        op("R10 lower at 176", 1, 176, 0, 0, 0);
        op("R10 raise at 164", 1, 164, 0, 0, 0);
        op("R8 step write with sample", 1, 100, 1, 2, 4);
        op("R8 new step", 1, 100, 0, 0, 0);
        op("R8 max write", 0, 0, 1, 1, 14);
        op("R3 saturate", 1, 100, 0, 0, 0);
        op("R3 at max hold", 1, 100, 0, 0, 0);
        op("R8 target write with sample", 1, 250, 1, 3, 300);
        op("R3 max raise", 0, 0, 1, 1, 30);
        op("R8 new target raise", 1, 250, 0, 0, 0);
        op("R4 lower", 1, 900, 0, 0, 0);
        op("R4 lower", 1, 900, 0, 0, 0);
        op("R4 lower", 1, 900, 0, 0, 0);
        op("R4 lower to floor", 1, 900, 0, 0, 0);
        op("R4 floor hold", 1, 900, 0, 0, 0);
        op("R9 base lift", 0, 0, 1, 0, 20);
        idle("R9 strobe drop");
        op("R4 at base hold", 1, 1000, 0, 0, 0);
        op("R8 base write with sample", 1, 900, 1, 0, 3);
        op("R4 lower to new base range", 1, 900, 0, 0, 0);
        op("R3 raise to max", 1, 10, 0, 0, 0);
        op("R3 raise to max", 1, 10, 0, 0, 0);
        op("R3 raise to max", 1, 10, 0, 0, 0);
        op("R3 no wrap", 1, 10, 0, 0, 0);
        op("R9 lift same cycle as raise", 1, 10, 1, 0, 31);
        idle("R6 idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule